// File: doc/BRIEF.md
# Indexed-Select Vectored Interrupt Controller

This block gathers up to 128 interrupt sources and drives one request line to a processor. Software reaches each source through an index register: it writes a source number there first, and the configuration registers and the one-shot command registers then act on that source alone. Each source has a 3-bit priority, a trigger style (level or edge, either polarity), a vector word and an enable bit.

Among sources that are pending and enabled, the controller picks the one with the highest priority and drives the request line. A read of the vector register acknowledges that source. It returns the source's vector, records the source's priority on an 8-entry nesting stack, and from then on raises the request line only for strictly higher priorities. A write to the end-of-interrupt register pops one level. If no source may be taken, the vector read returns a programmable spurious word and pushes a placeholder entry, so each read is unwound by exactly one end-of-interrupt write. The bus is a plain strobe register bus; read data is combinational from the address. A cycle with both strobes high performs only the write.

Register offsets: select 0x00, mode 0x04, vector 0x08, vector read/acknowledge 0x10, in-service status 0x18, raw pending words 0x20/0x24/0x28/0x2C, enable status 0x30, request status 0x34, end-of-interrupt 0x38, spurious vector 0x3C, enable 0x40, disable 0x44, clear 0x48, set 0x4C.

Top module: `sel_vec_intc`

## Requirements
- R1: A write to the select register keeps only bits [6:0]; reading offset 0x00 returns that 7-bit index zero-extended.
- R2: Mode (0x04) and vector (0x08) read and write the values of the selected source only. Mode bits [2:0] hold the priority, bit 5 selects edge triggering (0 = level), bit 6 selects the active-low/falling polarity, and all other bits read 0.
- R3: A write to 0x40 or 0x44 with data bit 0 set enables or disables the selected source, and no other one. Data bit 0 clear has no effect. Offset 0x30 bit 0 reads the enable of the selected source. A disabled source never raises the request line.
- R4: An edge source latches pending on its active input edge and stays pending after the input returns. Pending word k (0x20+4k) bit j shows source 32k+j.
- R5: The pending state of a level source follows its input (inverted when active-low).
- R6: A write to 0x4C with bit 0 set forces the selected source pending. A write to 0x48 with bit 0 set clears its latched pending state.
- R7: The winner is the pending, enabled source with the highest priority (7 highest); ties go to the lowest index. A vector read returns the winner's vector, and 0x34 bit 0 mirrors the request line.
- R8: When no source is eligible, a vector read returns the spurious register (0x3C) and in-service status 0x18 reads 0.
- R9: A vector read with an eligible winner clears the winner's latched pending state and makes 0x18 read {bit 7 = 1, bits [6:0] = source index}. Until it is popped, only strictly higher priorities raise the request line.
- R10: A write to 0x38 pops one nesting level. The stack holds 8 entries and ignores pushes when full, so 8 writes unwind any sequence of vector reads.
- R11: After reset all sources are disabled with mode, vector and spurious registers zero, the request line is low, and a vector read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (side effects at the clock edge) |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| src_i | input | NUM_SRC | Interrupt source inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Directed scenarios drive single edge and level sources, which separates latched pending state from pending state that follows the input. They also drive two equal-priority level sources together, which shows the index tie-break, and a higher-priority edge on top of an acknowledged level source, which exposes the strict-greater nesting threshold and the order in which levels pop. A run of nine vector reads against a single level source fills the stack past its depth and shows that eight end-of-interrupt writes bring the request back. Set, clear, disable and a high source index check the command indirection and the pending word positions.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int SEL_W  = 7;
  localparam int PRIO_W = 3;
  localparam int MAX_SRC = 1 << SEL_W;

  localparam logic [7:0] OFF_SEL   = 8'h00;
  localparam logic [7:0] OFF_MODE  = 8'h04;
  localparam logic [7:0] OFF_VEC   = 8'h08;
  localparam logic [7:0] OFF_VRD   = 8'h10;
  localparam logic [7:0] OFF_INSV  = 8'h18;
  localparam logic [7:0] OFF_PND0  = 8'h20;
  localparam logic [7:0] OFF_PND1  = 8'h24;
  localparam logic [7:0] OFF_PND2  = 8'h28;
  localparam logic [7:0] OFF_PND3  = 8'h2C;
  localparam logic [7:0] OFF_ENST  = 8'h30;
  localparam logic [7:0] OFF_REQST = 8'h34;
  localparam logic [7:0] OFF_EOI   = 8'h38;
  localparam logic [7:0] OFF_SPUR  = 8'h3C;
  localparam logic [7:0] OFF_ENA   = 8'h40;
  localparam logic [7:0] OFF_DIS   = 8'h44;
  localparam logic [7:0] OFF_CLR   = 8'h48;
  localparam logic [7:0] OFF_SET   = 8'h4C;

  typedef struct packed {
    logic              act_low;
    logic              edge_trig;
    logic [PRIO_W-1:0] prio;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef struct packed {
    logic              lvl_v;
    logic [PRIO_W-1:0] lvl;
    logic              cur_v;
    logic [SEL_W-1:0]  idx;
  } nest_t;
endpackage

// File: rtl/intc_src_bank.sv
`timescale 1ns/1ps
module intc_src_bank
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int VEC_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic                       wr_mode_i,
  input  logic                       wr_vec_i,
  input  logic [31:0]                wdata_i,
  input  logic                       en_cmd_i,
  input  logic                       dis_cmd_i,
  input  logic                       clr_cmd_i,
  input  logic                       set_cmd_i,
  input  logic                       ack_i,
  input  logic [SEL_W-1:0]           ack_idx_i,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_o,
  output logic [NUM_SRC-1:0]         enable_o,
  output logic [NUM_SRC-1:0]         pend_o,
  output logic [NUM_SRC*VEC_W-1:0]   vec_o,
  output mode_t                      sel_mode_o,
  output logic [VEC_W-1:0]           sel_vec_o
);
  logic [NUM_SRC*MODE_W-1:0] mode_flat;
  logic [NUM_SRC-1:0]        latch_flat;
  logic [NUM_SRC-1:0]        set_now;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    mode_t            m_q;
    logic [VEC_W-1:0] v_q;
    logic             en_q, pl_q, prev_q, hit, act_edge, clr_now;

    assign hit      = (sel_i == SEL_W'(g));
    assign act_edge = m_q.act_low ? (prev_q & ~src_i[g]) : (~prev_q & src_i[g]);
    assign set_now[g] = (hit & set_cmd_i) | (m_q.edge_trig & act_edge);
    assign clr_now  = (hit & clr_cmd_i) | (ack_i & (ack_idx_i == SEL_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q    <= '0;
        v_q    <= '0;
        en_q   <= 1'b0;
        pl_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        prev_q <= src_i[g];
        if (hit && wr_mode_i) m_q <= mode_t'({wdata_i[6:5], wdata_i[PRIO_W-1:0]});
        if (hit && wr_vec_i)  v_q <= wdata_i[VEC_W-1:0];
        if (hit && en_cmd_i)       en_q <= 1'b1;
        else if (hit && dis_cmd_i) en_q <= 1'b0;
        if (set_now[g])   pl_q <= 1'b1;
        else if (clr_now) pl_q <= 1'b0;
      end
    end

    assign mode_flat[g*MODE_W +: MODE_W] = m_q;
    assign prio_o[g*PRIO_W +: PRIO_W]    = m_q.prio;
    assign vec_o[g*VEC_W +: VEC_W]       = v_q;
    assign enable_o[g]   = en_q;
    assign latch_flat[g] = pl_q;
    assign pend_o[g]     = pl_q | (~m_q.edge_trig & (src_i[g] ^ m_q.act_low));
  end

  always_comb begin
    sel_mode_o = '0;
    sel_vec_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_i == SEL_W'(i)) begin
        sel_mode_o = mode_t'(mode_flat[i*MODE_W +: MODE_W]);
        sel_vec_o  = vec_o[i*VEC_W +: VEC_W];
      end
    end
  end

  // R3: a command touches at most one enable bit per cycle
  a_r3_single_enable_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(enable_o ^ $past(enable_o)) <= 1);

  // R9: acknowledge drops the latched pending state unless a new set arrives
  a_r9_ack_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_now[ack_idx_i]) |=> !latch_flat[$past(ack_idx_i)]);
endmodule

// File: rtl/intc_prio_arb.sv
`timescale 1ns/1ps
module intc_prio_arb
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      found_o,
  output logic [SEL_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
        found_o = 1'b1;
        idx_o   = SEL_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intc_nest_stack.sv
`timescale 1ns/1ps
module intc_nest_stack
  import intc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  nest_t            push_ent_i,
  input  logic             pop_i,
  output nest_t            top_o,
  output logic [CNT_W-1:0] cnt_o
);
  nest_t            stk [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (pop_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end else if (push_i && cnt_q < CNT_W'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (cnt_q == CNT_W'(i)) stk[i] <= push_ent_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CNT_W'(i + 1)) top_o = stk[i];
  end

  assign cnt_o = cnt_q;

  // R10: depth never exceeds the stack size
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R10: each end-of-interrupt removes exactly one level when any is held
  a_r10_pop_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sel_vec_intc.sv
`timescale 1ns/1ps
module sel_vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC    = 128,
  parameter int VEC_W      = 32,
  parameter int NEST_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  localparam int CNT_W = $clog2(NEST_DEPTH + 1);

  logic [SEL_W-1:0]          sel_q;
  logic [VEC_W-1:0]          spur_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        en_vec, pend_vec;
  logic [NUM_SRC*VEC_W-1:0]  vec_flat;
  mode_t                     sel_mode;
  logic [VEC_W-1:0]          sel_vec, win_vec;
  logic                      found, eligible, rd_act, push, pop, ack;
  logic [SEL_W-1:0]          win_idx;
  logic [PRIO_W-1:0]         win_prio;
  nest_t                     top, push_ent;
  logic [CNT_W-1:0]          depth;
  logic [MAX_SRC-1:0]        pend_pad;

  function automatic logic cmd(input logic [7:0] off);
    return bus_wr_i && bus_addr_i == off && bus_wdata_i[0];
  endfunction

  assign rd_act = bus_rd_i && !bus_wr_i;
  assign push   = rd_act && bus_addr_i == OFF_VRD;
  assign pop    = bus_wr_i && bus_addr_i == OFF_EOI;
  assign ack    = push && eligible;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      spur_q <= '0;
    end else if (bus_wr_i) begin
      if (bus_addr_i == OFF_SEL)  sel_q  <= bus_wdata_i[SEL_W-1:0];
      if (bus_addr_i == OFF_SPUR) spur_q <= bus_wdata_i[VEC_W-1:0];
    end
  end

  intc_src_bank #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_bank (
    .clk, .rst_n, .src_i,
    .sel_i(sel_q),
    .wr_mode_i(bus_wr_i && bus_addr_i == OFF_MODE),
    .wr_vec_i (bus_wr_i && bus_addr_i == OFF_VEC),
    .wdata_i(bus_wdata_i),
    .en_cmd_i(cmd(OFF_ENA)), .dis_cmd_i(cmd(OFF_DIS)),
    .clr_cmd_i(cmd(OFF_CLR)), .set_cmd_i(cmd(OFF_SET)),
    .ack_i(ack), .ack_idx_i(win_idx),
    .prio_o(prio_flat), .enable_o(en_vec), .pend_o(pend_vec), .vec_o(vec_flat),
    .sel_mode_o(sel_mode), .sel_vec_o(sel_vec)
  );

  intc_prio_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i(pend_vec & en_vec), .prio_i(prio_flat),
    .found_o(found), .idx_o(win_idx), .prio_o(win_prio)
  );

  assign push_ent = eligible ? nest_t'({1'b1, win_prio, 1'b1, win_idx})
                             : nest_t'({top.lvl_v, top.lvl, 1'b0, {SEL_W{1'b0}}});

  intc_nest_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk, .rst_n, .push_i(push), .push_ent_i(push_ent), .pop_i(pop),
    .top_o(top), .cnt_o(depth)
  );

  assign eligible = found && (!top.lvl_v || win_prio > top.lvl);
  assign irq_o    = eligible;

  always_comb begin
    win_vec = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (win_idx == SEL_W'(i)) win_vec = vec_flat[i*VEC_W +: VEC_W];
  end

  assign pend_pad = MAX_SRC'(pend_vec);

  always_comb begin
    case (bus_addr_i)
      OFF_SEL:   bus_rdata_o = 32'(sel_q);
      OFF_MODE:  bus_rdata_o = 32'({sel_mode.act_low, sel_mode.edge_trig, 2'b00, sel_mode.prio});
      OFF_VEC:   bus_rdata_o = 32'(sel_vec);
      OFF_VRD:   bus_rdata_o = eligible ? 32'(win_vec) : 32'(spur_q);
      OFF_INSV:  bus_rdata_o = top.cur_v ? 32'({1'b1, top.idx}) : 32'd0;
      OFF_PND0:  bus_rdata_o = pend_pad[31:0];
      OFF_PND1:  bus_rdata_o = pend_pad[63:32];
      OFF_PND2:  bus_rdata_o = pend_pad[95:64];
      OFF_PND3:  bus_rdata_o = pend_pad[127:96];
      OFF_ENST:  bus_rdata_o = 32'(en_vec[sel_q]);
      OFF_REQST: bus_rdata_o = 32'(irq_o);
      OFF_SPUR:  bus_rdata_o = 32'(spur_q);
      default:   bus_rdata_o = 32'd0;
    endcase
  end

  // R7: the chosen source is always both pending and enabled
  a_r7_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend_vec[win_idx] && en_vec[win_idx]));

  // R9: an acknowledge with room on the stack records the winner's level as the threshold
  a_r9_ack_sets_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && depth < CNT_W'(NEST_DEPTH)) |=> (top.lvl_v && top.lvl == $past(win_prio)));

  // R8: a placeholder entry never reports a source in service
  a_r8_spurious_no_service: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !eligible && depth < CNT_W'(NEST_DEPTH)) |=> !top.cur_v);
endmodule

// File: tb/sel_vec_intc_test.sv
`timescale 1ns/1ps
module sel_vec_intc_test;
  localparam int N = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] src = '0;
  logic         irq;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  sel_vec_intc uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic drive_src(input int i, input logic v);
    @(negedge clk); src[i] = v;
    @(negedge clk);
  endtask

  task automatic expect_irq(input string req, input logic exp);
    #1 check(req, 32'(irq), 32'(exp));
  endtask

  task automatic t_reset;
    expect_irq("R11 irq low", 1'b0);
    expect_rd("R11 enable status", 8'h30, 0);
    expect_rd("R11 spurious zero vector", 8'h10, 0);
    expect_rd("R8 no in-service", 8'h18, 0);
    bus_wr(8'h38, 0);
  endtask

  task automatic t_select;
    bus_wr(8'h00, 32'h85);
    expect_rd("R1 select low bits", 8'h00, 32'h05);
  endtask

  task automatic t_config;
    bus_wr(8'h00, 3);  bus_wr(8'h04, 32'h25); bus_wr(8'h08, 32'h300);
    bus_wr(8'h00, 10); bus_wr(8'h04, 32'h02); bus_wr(8'h08, 32'h1000);
    bus_wr(8'h00, 40); bus_wr(8'h04, 32'h02); bus_wr(8'h08, 32'h4000);
    bus_wr(8'h00, 3);
    expect_rd("R2 mode of src3", 8'h04, 32'h25);
    expect_rd("R2 vector of src3", 8'h08, 32'h300);
    bus_wr(8'h04, 32'hFF);
    expect_rd("R2 mode field mask", 8'h04, 32'h67);
    bus_wr(8'h04, 32'h25);
    bus_wr(8'h00, 10);
    expect_rd("R2 vector of src10", 8'h08, 32'h1000);
  endtask

  task automatic t_enable;
    bus_wr(8'h00, 3);  bus_wr(8'h40, 1);
    bus_wr(8'h00, 10); bus_wr(8'h40, 1);
    bus_wr(8'h00, 40); bus_wr(8'h40, 1);
    bus_wr(8'h00, 4);  bus_wr(8'h40, 0);
    expect_rd("R3 bit0 clear ignored", 8'h30, 0);
    bus_wr(8'h00, 3);
    expect_rd("R3 selected enabled", 8'h30, 1);
  endtask

  task automatic t_edge;
    drive_src(3, 1'b1);
    drive_src(3, 1'b0);
    expect_rd("R4 edge latched", 8'h20, 32'h8);
    expect_irq("R7 irq from edge", 1'b1);
    expect_rd("R7 request status", 8'h34, 1);
    expect_rd("R7 vector of winner", 8'h10, 32'h300);
    expect_rd("R9 in-service src3", 8'h18, 32'h83);
    expect_rd("R9 ack clears latch", 8'h20, 0);
    expect_irq("R9 irq dropped", 1'b0);
    bus_wr(8'h38, 0);
    expect_rd("R10 pop empties", 8'h18, 0);
  endtask

  task automatic t_level;
    drive_src(10, 1'b1);
    expect_rd("R5 level pending", 8'h20, 32'h400);
    expect_irq("R5 level irq", 1'b1);
    drive_src(10, 1'b0);
    expect_rd("R5 level released", 8'h20, 0);
    expect_irq("R5 irq released", 1'b0);
  endtask

  task automatic t_priority;
    @(negedge clk); src[10] = 1'b1; src[40] = 1'b1;
    expect_rd("R7 tie to lowest index", 8'h10, 32'h1000);
    expect_irq("R9 equal prio masked", 1'b0);
    drive_src(3, 1'b1);
    expect_irq("R9 higher prio nests", 1'b1);
    expect_rd("R9 nested vector", 8'h10, 32'h300);
    expect_rd("R9 nested in-service", 8'h18, 32'h83);
    bus_wr(8'h38, 0);
    expect_rd("R10 pop to outer", 8'h18, 32'h8A);
    bus_wr(8'h38, 0);
    expect_rd("R10 pop to empty", 8'h18, 0);
    expect_irq("R10 level rearms", 1'b1);
    @(negedge clk); src[3] = 1'b0; src[10] = 1'b0; src[40] = 1'b0;
    expect_irq("R5 all released", 1'b0);
  endtask

  task automatic t_set_clear;
    bus_wr(8'h00, 3); bus_wr(8'h4C, 1);
    expect_rd("R6 set forces pending", 8'h20, 32'h8);
    expect_irq("R6 set raises irq", 1'b1);
    bus_wr(8'h48, 1);
    expect_rd("R6 clear drops pending", 8'h20, 0);
    bus_wr(8'h44, 1); bus_wr(8'h4C, 1);
    expect_irq("R3 disabled source silent", 1'b0);
    bus_wr(8'h48, 1);
    bus_wr(8'h00, 70); bus_wr(8'h4C, 1);
    expect_rd("R4 word2 bit6 is src70", 8'h28, 32'h40);
    bus_wr(8'h48, 1);
  endtask

  task automatic t_spurious;
    bus_wr(8'h3C, 32'hBEEF);
    expect_rd("R8 spurious vector", 8'h10, 32'hBEEF);
    expect_rd("R8 in-service zero", 8'h18, 0);
    bus_wr(8'h38, 0);
  endtask

  task automatic t_unwind;
    logic [31:0] d;
    drive_src(10, 1'b1);
    expect_rd("R9 first ack", 8'h10, 32'h1000);
    for (int k = 0; k < 8; k++) bus_rd(8'h10, d);
    check("R8 repeated read spurious", d, 32'hBEEF);
    for (int k = 0; k < 7; k++) bus_wr(8'h38, 0);
    expect_irq("R10 seven pops hold level", 1'b0);
    expect_rd("R10 bottom entry real", 8'h18, 32'h8A);
    bus_wr(8'h38, 0);
    expect_irq("R10 eight pops unwind", 1'b1);
    expect_rd("R10 stack empty", 8'h18, 0);
    drive_src(10, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_config();
    t_enable();
    t_edge();
    t_level();
    t_priority();
    t_set_clear();
    t_spurious();
    t_unwind();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule